// File: doc/BRIEF.md
# SD Host Status and Interrupt Register

This block holds the event and error status word of an SD/MMC host controller, together with the interrupt enable word, and drives the controller's interrupt line. The command, data and card-detect engines report one-cycle event pulses. Each pulse sets a sticky flag that stays set until software writes a one to its position. Buffer-ready, buffer-empty and buffer-full flags are not stored. They always show the live level inputs. A two-bit write CRC status code from the data engine also appears live in the status word.

Software reaches both words through a single-cycle register port: a write strobe with a word select, and a combinational read mux with its own select. The interrupt line is a registered-state function of the stored flags, the level flags and the enable word. It changes in the cycle after the event or write that caused it. A separate error output is high while any flag in the error group is set.

Top module: `sdst_status_ctrl`

## Requirements
- R1: After reset the stored status flags and the enable word are all zero, `irq_o` is low and `err_o` is low.
- R2: An `evt_i` pulse on a sticky position sets that status bit at the next clock edge, and the bit stays set. The sticky positions are 31 card inserted, 30 card removed, 25 underrun, 24 overflow, 14 SDIO interrupt, 13 command response end, 12 write done, 11 read/transfer done, 5 response CRC error, 3 read CRC error, 2 write CRC error, 1 response timeout and 0 read timeout.
- R3: A status write (`wr_en`=1, `wr_sel`=0) clears every sticky bit whose `wr_data` bit is one. A zero in `wr_data` leaves that bit unchanged.
- R4: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 29, 28, 27, 26, 7 and 6 (second buffer empty, first buffer empty, second buffer full, first buffer full, buffer read ready, buffer write ready) always equal the same bits of `lvl_i`. Events and writes have no effect on them, and the other bits of `lvl_i` are ignored.
- R6: Status bits 10:9 show `wcrc_code_i` live. Code 2 means the card returned no CRC status token.
- R7: `err_o` is high exactly while a stored status bit under the error mask 0x2f (bits 5, 3, 2, 1, 0) is set.
- R8: An enable write (`wr_en`=1, `wr_sel`=1) loads bits 18:12 and 4:0 of `wr_data`. The other enable bits read as zero.
- R9: `irq_o` is the OR of these enable/status pairs: en15&st31, en14&st30, en13&st14, en2&st13, en1&st12, en0&st11, en4&st7, en3&st6.
- R10: Enable bits 18, 17, 16 (wake-up) and 12 (DAT0) never raise `irq_o`.
- R11: Status bits 23:15, 8 and 4 read as zero, and events on them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | One-cycle event pulses, one per status position |
| lvl_i | input | 32 | Live level flags for the buffer-state positions |
| wcrc_code_i | input | 2 | Write CRC status code from the data engine |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 enable |
| rd_data | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| err_o | output | 1 | Any error flag set |

## Verification
A sticky flag that fails to set, or fails to clear, shows on `rd_data` one cycle after the event or write. It also shows on `irq_o` or `err_o` when the flag's enable or error group is active. A wrong entry in the enable-to-status pairing is invisible until that exact pair is exercised. For that reason the bench enables single bits and fires single events. A lost set/clear priority only shows in the cycle where an event and a clearing write coincide, so that collision is driven on purpose.

// File: rtl/sdst_pkg.sv
package sdst_pkg;
  localparam int unsigned SW = 32;
  // stored flags: card in/out, underrun/overflow, done flags, errors
  localparam logic [SW-1:0] STICKY_MASK = 32'hC300_782F;
  // live buffer-state flags
  localparam logic [SW-1:0] LEVEL_MASK  = 32'h3C00_00C0;
  localparam int unsigned   CODE_LSB    = 9;
  localparam int unsigned   CODE_W      = 2;
  localparam logic [SW-1:0] ERROR_MASK  = 32'h0000_002F;
  localparam logic [SW-1:0] ENABLE_MASK = 32'h0007_F01F;
  localparam int unsigned   NPAIR       = 8;
  typedef int unsigned pos_list_t [NPAIR];
  localparam pos_list_t EN_POS = '{15, 14, 13, 2, 1, 0, 4, 3};
  localparam pos_list_t ST_POS = '{31, 30, 14, 13, 12, 11, 7, 6};
endpackage

// File: rtl/sdst_sticky_bank.sv
module sdst_sticky_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_store
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set_i[i] | (q & ~(clr_en & clr_i[i]));
      end
      assign q_o[i] = q;
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end
  logic unused_bits;
  assign unused_bits = ^{set_i & ~MASK, clr_i & ~MASK};
endmodule

// File: rtl/sdst_en_reg.sv
module sdst_en_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d & MASK;
  end
  assign q_o = q;
endmodule

// File: rtl/sdst_irq_map.sv
module sdst_irq_map
  import sdst_pkg::*;
(
  input  logic [SW-1:0] stat_i,
  input  logic [SW-1:0] en_i,
  output logic          irq_o
);
  logic [NPAIR-1:0] hit;
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign hit[k] = en_i[EN_POS[k]] & stat_i[ST_POS[k]];
  end
  assign irq_o = |hit;
  logic unused_bits;
  assign unused_bits = ^{stat_i, en_i};
endmodule

// File: rtl/sdst_status_ctrl.sv
module sdst_status_ctrl
  import sdst_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] evt_i,
  input  logic [SW-1:0] lvl_i,
  input  logic [1:0]    wcrc_code_i,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [SW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [SW-1:0] rd_data,
  output logic          irq_o,
  output logic          err_o
);
  logic [SW-1:0] sticky_q;
  logic [SW-1:0] en_q;
  logic [SW-1:0] code_word;
  logic [SW-1:0] stat_w;

  sdst_sticky_bank #(.W(SW), .MASK(STICKY_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i),
    .clr_en(wr_en & ~wr_sel), .clr_i(wr_data), .q_o(sticky_q)
  );

  sdst_en_reg #(.W(SW), .MASK(ENABLE_MASK)) u_en (
    .clk(clk), .rst_n(rst_n), .ld(wr_en & wr_sel), .d(wr_data), .q_o(en_q)
  );

  always_comb begin
    code_word = '0;
    code_word[CODE_LSB +: CODE_W] = wcrc_code_i;
  end

  assign stat_w  = sticky_q | (lvl_i & LEVEL_MASK) | code_word;
  assign rd_data = rd_sel ? en_q : stat_w;
  assign err_o   = |(sticky_q & ERROR_MASK);

  sdst_irq_map u_irq (.stat_i(stat_w), .en_i(en_q), .irq_o(irq_o));
endmodule

// File: rtl/sdst_status_chk.sv
module sdst_status_chk
  import sdst_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] evt_i,
  input logic [SW-1:0] lvl_i,
  input logic          wr_en,
  input logic          wr_sel,
  input logic [SW-1:0] wr_data,
  input logic [SW-1:0] stat_w,
  input logic [SW-1:0] en_q,
  input logic          irq_o,
  input logic          err_o
);
  // R2 and R4: an event sets its bit regardless of a clearing write
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & STICKY_MASK) != '0) |=>
      ((stat_w & $past(evt_i & STICKY_MASK)) == $past(evt_i & STICKY_MASK)));
  // R3: written ones without an event end up cleared
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=>
      ((stat_w & $past(wr_data & STICKY_MASK & ~evt_i)) == '0));
  // R3: with no event and no status write, stored flags hold
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && !wr_sel) && ((evt_i & STICKY_MASK) == '0)) |=>
      ((stat_w & STICKY_MASK) == $past(stat_w & STICKY_MASK)));
  // R5: level flags follow the inputs
  a_r5_level: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w & LEVEL_MASK) == (lvl_i & LEVEL_MASK));
  // R11: reserved positions stay zero
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w & ~(STICKY_MASK | LEVEL_MASK | 32'h0000_0600)) == '0);
  // R8: enable only holds writable bits
  a_r8_en_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~ENABLE_MASK) == '0);
  // R7: an error event raises the error output next cycle
  a_r7_err: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & ERROR_MASK) != '0) |=> err_o);
  // R9: no interrupt without an enable and a flag
  a_r9_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((en_q != '0) && (stat_w != '0)));
endmodule

bind sdst_status_ctrl sdst_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .stat_w(stat_w), .en_q(en_q), .irq_o(irq_o), .err_o(err_o)
);

// File: tb/sim_sdst_status_ctrl.sv
module sim_sdst_status_ctrl;
  localparam time TCLK = 10ns;
  localparam int  NROW = 10;

  typedef struct packed {
    logic [31:0] evt;
    logic [31:0] clr;
    logic [31:0] exp;
  } row_t;

  // walked from reset, lvl_i=0, code=0, status write every row
  localparam row_t TBL [NROW] = '{
    '{32'h0000_2000, 32'h0000_0000, 32'h0000_2000}, // R2 cmd end
    '{32'h0000_0003, 32'h0000_0000, 32'h0000_2003}, // R2 timeouts
    '{32'h0000_0000, 32'h0000_2000, 32'h0000_0003}, // R3 clear one
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0003}, // R4 set wins
    '{32'hC000_0000, 32'hFFFF_FFFF, 32'hC000_0000}, // R4 with full clear
    '{32'h3C00_00C0, 32'h0000_0000, 32'hC000_0000}, // R5 events on level bits
    '{32'h0000_0000, 32'h0000_0000, 32'hC000_0000}, // R3 zero write
    '{32'h0300_782C, 32'h8000_0000, 32'h4300_782C}, // R2 R3 mixed
    '{32'h00FF_0710, 32'h0000_0000, 32'h4300_782C}, // R11 reserved events
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000}  // R3 clear all
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0, lvl_i = '0, wr_data = '0, rd_data;
  logic [1:0]  wcrc_code_i = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic        irq_o, err_o;
  int          n_chk = 0, n_err = 0;

  always #(TCLK/2) clk = ~clk;

  sdst_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
    .wcrc_code_i(wcrc_code_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_o(irq_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one cycle of stimulus, then return at the next falling edge
  task automatic cyc(input logic [31:0] ev, input logic we, input logic sel, input logic [31:0] d);
    evt_i = ev; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    evt_i = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(TCLK * 5000);
    n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_sel = 1'b0; #1 check("R1 status", rd_data, 32'h0);
    rd_sel = 1'b1; #1 check("R1 enable", rd_data, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);
    check("R1 err", {31'h0, err_o}, 32'h0);
    rd_sel = 1'b0;

    for (int i = 0; i < NROW; i++) begin
      cyc(TBL[i].evt, 1'b1, 1'b0, TBL[i].clr);
      check($sformatf("R2/R3/R4/R11 row %0d", i), rd_data, TBL[i].exp);
    end

    // R7 error output
    check("R7 err idle", {31'h0, err_o}, 32'h0);
    cyc(32'h0000_0004, 1'b0, 1'b0, '0);
    check("R7 err set", {31'h0, err_o}, 32'h1);
    cyc(32'h0, 1'b1, 1'b0, 32'h0000_0004);
    check("R7 err cleared", {31'h0, err_o}, 32'h0);

    // R5 and R6 live fields
    lvl_i = 32'hFFFF_FFFF; wcrc_code_i = 2'd2; #1;
    check("R5 R6 live", rd_data, 32'h3C00_04C0);
    wcrc_code_i = 2'd1; #1;
    check("R6 code 1", rd_data, 32'h3C00_02C0);
    cyc(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    check("R5 write ignored", rd_data, 32'h3C00_02C0);
    lvl_i = '0; wcrc_code_i = '0; #1;
    check("R5 follow low", rd_data, 32'h0);

    // R8 enable word
    cyc(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    rd_sel = 1'b1; #1 check("R8 enable bits", rd_data, 32'h0007_F01F);
    rd_sel = 1'b0;
    check("R9 no flag no irq", {31'h0, irq_o}, 32'h0);

    // R9 each pair individually
    begin
      int unsigned ep [8] = '{15, 14, 13, 2, 1, 0, 4, 3};
      int unsigned sp [8] = '{31, 30, 14, 13, 12, 11, 7, 6};
      for (int k = 0; k < 8; k++) begin
        cyc(32'h0, 1'b1, 1'b1, 32'h1 << ep[k]);
        if (sp[k] < 8) begin
          lvl_i = 32'h1 << sp[k]; #1;
          check($sformatf("R9 level pair %0d", k), {31'h0, irq_o}, 32'h1);
          lvl_i = '0; #1;
          check($sformatf("R9 level drop %0d", k), {31'h0, irq_o}, 32'h0);
        end else begin
          cyc(32'h1 << sp[k], 1'b0, 1'b0, '0);
          check($sformatf("R9 pair %0d", k), {31'h0, irq_o}, 32'h1);
          cyc(32'h0, 1'b1, 1'b0, 32'h1 << sp[k]);
          check($sformatf("R9 clear %0d", k), {31'h0, irq_o}, 32'h0);
        end
      end
    end

    // R9 mismatched pair gives nothing
    cyc(32'h0, 1'b1, 1'b1, 32'h0000_8000);
    cyc(32'h4000_0000, 1'b0, 1'b0, '0);
    check("R9 wrong pair", {31'h0, irq_o}, 32'h0);
    cyc(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);

    // R10 wake and DAT0 enables do nothing
    cyc(32'h0, 1'b1, 1'b1, 32'h0007_1000);
    cyc(32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    lvl_i = 32'hFFFF_FFFF; #1;
    check("R10 wake enables", {31'h0, irq_o}, 32'h0);
    lvl_i = '0;
    cyc(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);

    // R1 reset in the middle clears everything
    cyc(32'h0, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cyc(32'h0000_2000, 1'b0, 1'b0, '0);
    check("R9 before reset", {31'h0, irq_o}, 32'h1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #1;
    check("R1 reset status", rd_data, 32'h0);
    check("R1 reset irq", {31'h0, irq_o}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule